// File: doc/BRIEF.md
# Banked Shared Memory Conflict Serializer

This block takes one read request from a group of 32 lanes that run in lockstep. Each lane carries a byte address and an active bit. Shared memory is built from word-interleaved banks, each one 4-byte word wide. The word index selects the bank, and the remaining upper address bits select the row inside that bank. Lanes that land in different banks are served in the same cycle. Lanes that land on different rows of one bank are served one after another. Lanes that name the same word are merged and share one read.

The block latches the request and then issues reads to the per-bank SRAM ports. In each issue cycle, every bank serves the row of its lowest-numbered pending lane, together with every pending lane that wants that same row. Each bank SRAM returns data one cycle after the read enable. Once every active lane holds its word, the block raises a single-cycle done pulse with the gathered per-lane data.

The number of issue cycles therefore equals the largest number of distinct words requested from any one bank. A new request is refused until the current one has been answered.

Top module: `smem_bank_serializer`

## Requirements
- R1: Byte address bits [1:0] pick a byte within a word and do not affect the access. Bits [6:2] give the bank index. Bits [ADDR_W-1:7] give the row presented on that bank's row port. A lane always receives the full 32-bit word.
- R2: When every active lane maps to a different bank, the request uses exactly one issue cycle, meaning one cycle with any bank read enable high.
- R3: The number of issue cycles for a request equals the largest count of distinct rows requested from any single bank. These issue cycles are consecutive and start in the cycle right after acceptance.
- R4: Active lanes that name the same word, including the case where all lanes do, are served by a single bank read. An all-same-word request uses one issue cycle.
- R5: Inactive lanes take no bank read and return zero data. A request with no active lane uses zero issue cycles.
- R6: `req_ready` is high when the block is idle. It is low from the cycle after acceptance up to and including the done cycle, and high again in the cycle after the done cycle.
- R7: `resp_valid` is high for exactly one cycle. If acceptance happens at clock edge E0 and the request needs N issue cycles, `resp_valid` is high in the cycle that follows edge E(N+1).
- R8: During the done cycle, each active lane's slice of `resp_data` equals the word that its bank SRAM returned for that lane's row. The SRAM returns data one cycle after the read enable.
- R9: After reset, `req_ready` is high, and both `resp_valid` and all bank read enables are low.
- R10: Within one request, each bank's read enable is high in exactly as many cycles as the number of distinct rows its active lanes request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to accept |
| req_addr | input | LANES*ADDR_W | Per-lane byte addresses, lane l at [l*ADDR_W +: ADDR_W] |
| req_mask | input | LANES | Per-lane active bits |
| bank_rd_en | output | BANKS | Per-bank read enable |
| bank_rd_row | output | BANKS*ROW_W | Per-bank row, bank b at [b*ROW_W +: ROW_W] |
| bank_rd_data | input | BANKS*DATA_W | Per-bank read data, valid one cycle after enable |
| resp_valid | output | 1 | Single-cycle done pulse |
| resp_data | output | LANES*DATA_W | Per-lane read data, zero for inactive lanes |

## Verification
The bench targets the following corner cases:
- All 32 lanes stacked on one bank at 32 different rows. A design that merged by bank alone would finish in one cycle and return the wrong words.
- All lanes on a single word, and lanes that differ only in their byte offset. A design that did not broadcast would spend extra cycles and extra reads on these.
- Requests with inactive lanes parked on conflicting rows. A design that let masked lanes compete would stretch the request and return non-zero data for them.
- An empty mask, which must answer with no reads at all.
- Random mixes of rows and banks, which check the issue count, the per-bank read count and the exact done cycle. A design whose data capture slipped by one cycle against the SRAM latency would hand back the previous slot's words.

// File: rtl/smem_pkg.sv
package smem_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SERVE = 2'd1,
        ST_DRAIN = 2'd2,
        ST_DONE  = 2'd3
    } smem_state_e;

endpackage

// File: rtl/smem_bank_pick.sv
module smem_bank_pick #(
    parameter int unsigned LANES    = 32,
    parameter int unsigned BANK_W   = 5,
    parameter int unsigned ROW_W    = 7,
    parameter int unsigned BANK_IDX = 0
) (
    input  logic [LANES-1:0]        pending_i,
    input  logic [LANES*BANK_W-1:0] lane_bank_i,
    input  logic [LANES*ROW_W-1:0]  lane_row_i,
    output logic                    rd_en_o,
    output logic [ROW_W-1:0]        rd_row_o,
    output logic [LANES-1:0]        grant_o
);

    logic [LANES-1:0] cand;
    logic             found;

    // The lowest pending lane of this bank leads; lanes on the same row share the read.
    always_comb begin
        found    = 1'b0;
        rd_row_o = '0;
        for (int l = 0; l < LANES; l++) begin
            cand[l] = pending_i[l] &&
                      (lane_bank_i[l*BANK_W +: BANK_W] == BANK_W'(BANK_IDX));
        end
        for (int l = 0; l < LANES; l++) begin
            if (cand[l] && !found) begin
                found    = 1'b1;
                rd_row_o = lane_row_i[l*ROW_W +: ROW_W];
            end
        end
        for (int l = 0; l < LANES; l++) begin
            grant_o[l] = cand[l] && (lane_row_i[l*ROW_W +: ROW_W] == rd_row_o);
        end
        rd_en_o = found;
    end

endmodule

// File: rtl/smem_lane_collect.sv
module smem_lane_collect #(
    parameter int unsigned LANES  = 32,
    parameter int unsigned BANKS  = 32,
    parameter int unsigned BANK_W = 5,
    parameter int unsigned DATA_W = 32
) (
    input  logic [LANES-1:0]        grant_i,
    input  logic [LANES*BANK_W-1:0] lane_bank_i,
    input  logic [BANKS*DATA_W-1:0] bank_data_i,
    input  logic [LANES*DATA_W-1:0] data_q_i,
    output logic [LANES*DATA_W-1:0] data_d_o
);

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [BANK_W-1:0] sel;
        assign sel = lane_bank_i[l*BANK_W +: BANK_W];
        assign data_d_o[l*DATA_W +: DATA_W] =
            grant_i[l] ? bank_data_i[int'(sel)*DATA_W +: DATA_W]
                       : data_q_i[l*DATA_W +: DATA_W];
    end

endmodule

// File: rtl/smem_bank_serializer.sv
module smem_bank_serializer
    import smem_pkg::*;
#(
    parameter int unsigned LANES  = 32,
    parameter int unsigned BANKS  = 32,
    parameter int unsigned ADDR_W = 14,
    parameter int unsigned DATA_W = 32,
    localparam int unsigned OFS_W = $clog2(DATA_W / 8),
    localparam int unsigned BANK_W = $clog2(BANKS),
    localparam int unsigned ROW_W = ADDR_W - OFS_W - BANK_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic [LANES*ADDR_W-1:0] req_addr,
    input  logic [LANES-1:0]        req_mask,
    output logic [BANKS-1:0]        bank_rd_en,
    output logic [BANKS*ROW_W-1:0]  bank_rd_row,
    input  logic [BANKS*DATA_W-1:0] bank_rd_data,
    output logic                    resp_valid,
    output logic [LANES*DATA_W-1:0] resp_data
);

    typedef struct packed {
        smem_state_e             st;
        logic [LANES*ADDR_W-1:0] addr;
        logic [LANES-1:0]        pend;
        logic [LANES-1:0]        got;
        logic [LANES*DATA_W-1:0] data;
    } ser_regs_t;

    ser_regs_t q, d;

    logic [LANES*BANK_W-1:0] lane_bank;
    logic [LANES*ROW_W-1:0]  lane_row;
    logic [LANES-1:0]        grant_b [BANKS];
    logic [BANKS-1:0]        en_b;
    logic [BANKS*ROW_W-1:0]  row_b;
    logic [LANES-1:0]        grant_all;
    logic [LANES*DATA_W-1:0] data_next;

    // Address split: byte offset, bank index, row.
    for (genvar l = 0; l < LANES; l++) begin : g_split
        assign lane_bank[l*BANK_W +: BANK_W] = q.addr[l*ADDR_W + OFS_W +: BANK_W];
        assign lane_row[l*ROW_W +: ROW_W]    = q.addr[l*ADDR_W + OFS_W + BANK_W +: ROW_W];
    end

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        smem_bank_pick #(
            .LANES   (LANES),
            .BANK_W  (BANK_W),
            .ROW_W   (ROW_W),
            .BANK_IDX(b)
        ) u_pick (
            .pending_i  (q.pend),
            .lane_bank_i(lane_bank),
            .lane_row_i (lane_row),
            .rd_en_o    (en_b[b]),
            .rd_row_o   (row_b[b*ROW_W +: ROW_W]),
            .grant_o    (grant_b[b])
        );
    end

    always_comb begin
        grant_all = '0;
        for (int b = 0; b < BANKS; b++) begin
            grant_all = grant_all | grant_b[b];
        end
    end

    smem_lane_collect #(
        .LANES (LANES),
        .BANKS (BANKS),
        .BANK_W(BANK_W),
        .DATA_W(DATA_W)
    ) u_collect (
        .grant_i    (q.got),
        .lane_bank_i(lane_bank),
        .bank_data_i(bank_rd_data),
        .data_q_i   (q.data),
        .data_d_o   (data_next)
    );

    always_comb begin
        d = q;
        case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    d.addr = req_addr;
                    d.pend = req_mask;
                    d.got  = '0;
                    d.data = '0;
                    d.st   = (|req_mask) ? ST_SERVE : ST_DRAIN;
                end
            end
            ST_SERVE: begin
                d.pend = q.pend & ~grant_all;
                d.got  = grant_all;
                d.data = data_next;
                if ((q.pend & ~grant_all) == '0) begin
                    d.st = ST_DRAIN;
                end
            end
            ST_DRAIN: begin
                d.data = data_next;
                d.got  = '0;
                d.st   = ST_DONE;
            end
            default: begin
                d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign req_ready   = (q.st == ST_IDLE);
    assign resp_valid  = (q.st == ST_DONE);
    assign resp_data   = q.data;
    assign bank_rd_en  = (q.st == ST_SERVE) ? en_b : '0;
    assign bank_rd_row = row_b;

endmodule

// File: rtl/smem_bank_serializer_chk.sv
module smem_bank_serializer_chk #(
    parameter int unsigned LANES  = 32,
    parameter int unsigned BANKS  = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic [LANES-1:0] req_mask,
    input logic [BANKS-1:0] bank_rd_en,
    input logic             resp_valid
);

    logic accept;
    assign accept = req_valid && req_ready;

    // R6: once a request is taken, no second one is taken next cycle
    p_busy_after_accept_r6: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !req_ready);

    // R7: the done indication lasts a single cycle
    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);

    // R6: the block is not idle while it answers
    p_done_not_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> !req_ready);

    // R3: reads happen only while busy, never together with done
    p_issue_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (|bank_rd_en) |-> (!req_ready && !resp_valid));

    // R5: an empty request is answered two edges later with no read
    p_empty_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && req_mask == '0) |=> (bank_rd_en == '0) ##1 resp_valid);

    // R7: issuing stops before done rises
    p_done_after_issue_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(resp_valid) |-> $past(bank_rd_en) == '0);

endmodule

bind smem_bank_serializer smem_bank_serializer_chk #(
    .LANES(LANES),
    .BANKS(BANKS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_mask  (req_mask),
    .bank_rd_en(bank_rd_en),
    .resp_valid(resp_valid)
);

// File: tb/smem_bank_serializer_tb.sv
module smem_bank_serializer_tb;

    localparam int LANES   = 32;
    localparam int BANKS   = 32;
    localparam int ADDR_W  = 14;
    localparam int DATA_W  = 32;
    localparam int ROW_W   = ADDR_W - 2 - 5;
    localparam int CLK_PER = 10;
    localparam int WD_LIMIT = 100000;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    req_valid = 1'b0;
    logic                    req_ready;
    logic [LANES*ADDR_W-1:0] req_addr = '0;
    logic [LANES-1:0]        req_mask = '0;
    logic [BANKS-1:0]        bank_rd_en;
    logic [BANKS*ROW_W-1:0]  bank_rd_row;
    logic [BANKS*DATA_W-1:0] bank_rd_data = '0;
    logic                    resp_valid;
    logic [LANES*DATA_W-1:0] resp_data;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit done_flag = 0;

    always #(CLK_PER/2) clk = ~clk;

    smem_bank_serializer #(
        .LANES(LANES), .BANKS(BANKS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_mask(req_mask), .bank_rd_en(bank_rd_en),
        .bank_rd_row(bank_rd_row), .bank_rd_data(bank_rd_data),
        .resp_valid(resp_valid), .resp_data(resp_data)
    );

    function automatic logic [DATA_W-1:0] word_of(int bank, int row);
        return 32'hC0DE0000 | DATA_W'(row << 5) | DATA_W'(bank);
    endfunction

    // Bank SRAM model with one-cycle read latency
    always @(posedge clk) begin
        for (int b = 0; b < BANKS; b++) begin
            if (bank_rd_en[b])
                bank_rd_data[b*DATA_W +: DATA_W] <= word_of(b, int'(bank_rd_row[b*ROW_W +: ROW_W]));
        end
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > WD_LIMIT && !done_flag) begin
            bad = bad + 1;
            total = total + 1;
            $display("FAIL watchdog: actual=%0d expected<%0d", cyc, WD_LIMIT);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        total = total + 1;
        if (!ok) begin
            bad = bad + 1;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int bank_of(logic [ADDR_W-1:0] a);
        return int'(a[6:2]);
    endfunction

    function automatic int row_of(logic [ADDR_W-1:0] a);
        return int'(a[ADDR_W-1:7]);
    endfunction

    // distinct active rows requested from bank b
    function automatic int distinct_in_bank(logic [LANES*ADDR_W-1:0] ad, logic [LANES-1:0] m, int b);
        int cnt = 0;
        for (int i = 0; i < LANES; i++) begin
            bit first = 1;
            if (!m[i] || bank_of(ad[i*ADDR_W +: ADDR_W]) != b) continue;
            for (int j = 0; j < i; j++) begin
                if (m[j] && bank_of(ad[j*ADDR_W +: ADDR_W]) == b &&
                    row_of(ad[j*ADDR_W +: ADDR_W]) == row_of(ad[i*ADDR_W +: ADDR_W]))
                    first = 0;
            end
            if (first) cnt++;
        end
        return cnt;
    endfunction

    task automatic run_req(input string req);
        int n_exp = 0;
        int exp_cnt [BANKS];
        int got_cnt [BANKS];
        int issue = 0;
        int done_idx = -1;
        int pulses = 0;
        int ready_bad = 0;
        int bank_bad = 0;
        logic [LANES*DATA_W-1:0] cap = '0;
        logic [LANES*ADDR_W-1:0] ad = req_addr;
        logic [LANES-1:0] m = req_mask;
        for (int b = 0; b < BANKS; b++) begin
            exp_cnt[b] = distinct_in_bank(ad, m, b);
            got_cnt[b] = 0;
            if (exp_cnt[b] > n_exp) n_exp = exp_cnt[b];
        end
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        for (int idx = 0; idx <= n_exp + 3; idx++) begin
            if (|bank_rd_en) issue++;
            for (int b = 0; b < BANKS; b++) if (bank_rd_en[b]) got_cnt[b]++;
            if (resp_valid) begin
                pulses++;
                if (done_idx < 0) begin done_idx = idx; cap = resp_data; end
            end
            if (idx <= n_exp + 1 && req_ready) ready_bad++;
            if (idx == n_exp + 2 && !req_ready) ready_bad++;
            @(negedge clk);
        end
        chk(issue == n_exp, req, "issue cycles (R3)", issue, n_exp);
        chk(done_idx == n_exp + 1, "R7", "done cycle index", done_idx, n_exp + 1);
        chk(pulses == 1, "R7", "done pulse count", pulses, 1);
        chk(ready_bad == 0, "R6", "ready window mismatches", ready_bad, 0);
        for (int b = 0; b < BANKS; b++) if (got_cnt[b] != exp_cnt[b]) bank_bad++;
        chk(bank_bad == 0, "R10", "banks with wrong read count", bank_bad, 0);
        for (int l = 0; l < LANES; l++) begin
            logic [ADDR_W-1:0] a = ad[l*ADDR_W +: ADDR_W];
            logic [DATA_W-1:0] e = m[l] ? word_of(bank_of(a), row_of(a)) : '0;
            chk(cap[l*DATA_W +: DATA_W] == e, m[l] ? "R8" : "R5", $sformatf("lane %0d data", l),
                cap[l*DATA_W +: DATA_W], e);
        end
    endtask

    initial begin
        int unsigned seed = 32'h5EED_0042;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: reset state
        chk(req_ready == 1'b1, "R9", "ready after reset", req_ready, 1);
        chk(resp_valid == 1'b0, "R9", "resp_valid after reset", resp_valid, 0);
        chk(bank_rd_en == '0, "R9", "bank enables after reset", bank_rd_en, 0);

        // R2: every lane in its own bank
        for (int l = 0; l < LANES; l++) req_addr[l*ADDR_W +: ADDR_W] = ADDR_W'(l*4 + 3*128);
        req_mask = '1;
        run_req("R2");

        // R3: all lanes in bank 0 on 32 different rows
        for (int l = 0; l < LANES; l++) req_addr[l*ADDR_W +: ADDR_W] = ADDR_W'(l*128);
        run_req("R3");

        // R4: all lanes on one word
        for (int l = 0; l < LANES; l++) req_addr[l*ADDR_W +: ADDR_W] = ADDR_W'(14'h0040);
        run_req("R4");

        // R1: byte offsets inside a word do not split the access
        for (int l = 0; l < LANES; l++) req_addr[l*ADDR_W +: ADDR_W] = ADDR_W'(14'h200 + (l%4) + (l/4)*4);
        run_req("R1");

        // R3: two-way conflicts on 16 banks
        for (int l = 0; l < LANES; l++) req_addr[l*ADDR_W +: ADDR_W] = ADDR_W'((l%16)*4 + (l/16)*128);
        run_req("R3");

        // R5: empty mask
        req_mask = '0;
        run_req("R5");

        // R5: inactive lanes parked on conflicting rows
        for (int l = 0; l < LANES; l++)
            req_addr[l*ADDR_W +: ADDR_W] = (l < 16) ? ADDR_W'(l*4 + 256) : ADDR_W'((l-16)*128);
        req_mask = 32'h0000FFFF;
        run_req("R5");

        // random mixes
        for (int t = 0; t < 60; t++) begin
            for (int l = 0; l < LANES; l++) begin
                int bank = (t % 3 == 0) ? int'($urandom % 4) : int'($urandom % BANKS);
                int row  = int'($urandom % 4);
                int ofs  = int'($urandom % 4);
                req_addr[l*ADDR_W +: ADDR_W] = ADDR_W'(row*128 + bank*4 + ofs);
                req_mask[l] = ($urandom % 8) != 0;
            end
            run_req("R3");
        end

        done_flag = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule